// File: doc/BRIEF.md
# Flash Access Protection Checker

This block rules on every flash access request before it reaches the array. Each request carries an address, a requester (the on-chip CPU or an external debug/programming agent) and a read/write flag. The block maps the address to one of three areas: a boot area, a code area or a data area. It then grants or refuses the access. A refusal raises a one-cycle error pulse. The verdict is registered and appears on the cycle after the request.

Three protection layers combine. The first is a boot area. It starts at address zero and ends at a configured address, and it can never be written. The second is a set of per-section write-enable bits. Software sets them through a small register write port, and they cover program flash in 8 KiB sections and data flash in 512-byte sections. The third is a pair of 3-bit global fields in a protection word. Each field is decided by majority vote: one field stops all writes, and the other stops reads by the external agent only. The boot end address and the protection word are captured while reset is held, and they stay fixed until the next reset.

Top module: `flash_guard`

## Requirements
- R1: While reset is asserted, `acc_grant` and `acc_err` are low. After reset every section write-enable bit is zero, so any write to the code or data area is refused until its bit is set.
- R2: Addresses from 0x00000 up to and including the captured boot end form the boot area. A write there is always refused, whatever the enables and protection fields hold.
- R3: A boot end above 0x077FF on `cfg_boot_end` is clamped to 0x077FF.
- R4: The code area runs from boot end + 1 to 0x3FFFF. Its section index is address bits [17:13]. Register select 0 holds the enables for sections 0–15, one per bit (bit n = section n). Register select 1 holds sections 16–31 (bit n = section 16+n). A code write is granted only when its bit is set and global write protection is off.
- R5: The data area is 0xD0000–0xD1FFF. Its section index is address bits [12:9], and its enable is bit [12:9] of register select 2. A data write is granted only when that bit is set and global write protection is off.
- R6: Global write protection is on when at least two of `cfg_prot_word[2:0]` are zero. While it is on, every write is refused.
- R7: Global read protection is on when at least two of `cfg_prot_word[5:3]` are zero. While it is on, external reads (`acc_ext`=1) are refused. CPU reads of any mapped area are always granted, and so are external reads while read protection is off.
- R8: Any access to an address outside the three areas is refused.
- R9: `acc_grant` and `acc_err` are registered. For a request with `acc_valid`=1 in cycle n, exactly one of them is high in cycle n+1. With no request, both are low.
- R10: Boot end and protection word are sampled on every clock while reset is high. After release they hold, and later changes on those pins have no effect.
- R11: A register write takes effect from the next cycle. A request in the same cycle as the write is judged with the old enables. A write to select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_boot_end | input | 20 | Boot area last address, captured during reset |
| cfg_prot_word | input | 6 | [2:0] write-protect vote, [5:3] read-protect vote, captured during reset |
| reg_we | input | 1 | Enable-register write strobe |
| reg_sel | input | 2 | Enable register select (0,1 program; 2 data) |
| reg_wdata | input | 16 | Enable register write data |
| acc_valid | input | 1 | Access request present |
| acc_ext | input | 1 | 1 = external debug/programmer, 0 = CPU |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 20 | Access byte address |
| acc_grant | output | 1 | Access granted (one cycle after request) |
| acc_err | output | 1 | Access refused pulse (one cycle after request) |

## Verification
Every verdict is due exactly one clock after its request. A register write first changes verdicts for requests made on the following edge. The bench drives each request on a falling edge and advances its reference model only after the next rising edge has passed. It compares both outputs shortly after that rising edge, so each check sees the verdict for the request just made, judged with the enables that existed before any write issued in the same cycle. Captured configuration is compared on the first request after reset release, and again after the pins are changed.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int ADDR_W     = 20;
    localparam int REG_W      = 16;
    localparam int VOTE_W     = 3;
    localparam int PSEC_BYTES = 8192;
    localparam int DSEC_BYTES = 512;
    localparam int DATA_BYTES = 8192;

    localparam logic [ADDR_W-1:0] BOOT_MAX  = 20'h077FF;
    localparam logic [ADDR_W-1:0] CODE_TOP  = 20'h3FFFF;
    localparam logic [ADDR_W-1:0] DATA_BASE = 20'hD0000;
    localparam logic [ADDR_W-1:0] DATA_LAST = DATA_BASE + ADDR_W'(DATA_BYTES - 1);

    localparam int PSEC_N      = (int'(CODE_TOP) + 1) / PSEC_BYTES;
    localparam int DSEC_N      = DATA_BYTES / DSEC_BYTES;
    localparam int PSEC_IDX_W  = $clog2(PSEC_N);
    localparam int DSEC_IDX_W  = $clog2(DSEC_N);
    localparam int PSEC_SHIFT  = $clog2(PSEC_BYTES);
    localparam int DSEC_SHIFT  = $clog2(DSEC_BYTES);
    localparam int PROG_REGS   = PSEC_N / REG_W;
    localparam int DATA_REGS   = DSEC_N / REG_W;
    localparam int NUM_REGS    = PROG_REGS + DATA_REGS;
    localparam int SEL_W       = $clog2(NUM_REGS + 1);
    localparam int PWORD_W     = 2 * VOTE_W;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_BOOT = 2'd1,
        RGN_CODE = 2'd2,
        RGN_DATA = 2'd3
    } region_e;

    typedef enum logic {
        REQ_CPU = 1'b0,
        REQ_EXT = 1'b1
    } requester_e;

    // Packed MSB first: read vote occupies [5:3], write vote [2:0].
    typedef struct packed {
        logic [VOTE_W-1:0] rd_vote;
        logic [VOTE_W-1:0] wr_vote;
    } prot_word_t;

    typedef struct packed {
        logic              valid;
        requester_e        who;
        logic              write;
        logic [ADDR_W-1:0] addr;
    } access_t;

    typedef struct packed {
        region_e               rgn;
        logic [PSEC_IDX_W-1:0] psec;
        logic [DSEC_IDX_W-1:0] dsec;
    } locate_t;

    typedef struct packed {
        logic grant;
        logic deny;
    } verdict_t;

    typedef struct packed {
        logic wr_lock;
        logic rd_lock;
    } global_lock_t;

    // True when two or more of the three vote bits are clear.
    function automatic logic majority_clear(input logic [VOTE_W-1:0] v);
        int zeros;
        zeros = 0;
        for (int i = 0; i < VOTE_W; i++) begin
            if (!v[i]) zeros++;
        end
        return (zeros * 2 > VOTE_W);
    endfunction

    function automatic logic [ADDR_W-1:0] limit_boot(input logic [ADDR_W-1:0] a);
        return (a > BOOT_MAX) ? BOOT_MAX : a;
    endfunction

endpackage

// File: rtl/fg_cfg_latch.sv
module fg_cfg_latch
    import flash_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  boot_end_in,
    input  logic [PWORD_W-1:0] prot_in,
    output logic [ADDR_W-1:0]  boot_end,
    output global_lock_t       locks
);

    prot_word_t        pword_q;
    logic [ADDR_W-1:0] boot_q;

    // Tracks configuration while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            boot_q  <= limit_boot(boot_end_in);
            pword_q <= prot_word_t'(prot_in);
        end
    end

    always_comb begin
        boot_end      = boot_q;
        locks.wr_lock = majority_clear(pword_q.wr_vote);
        locks.rd_lock = majority_clear(pword_q.rd_vote);
    end

    p_boot_clamped_r3: assert property (@(posedge clk) disable iff (rst)
        boot_q <= BOOT_MAX);

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(boot_q) && $stable(pword_q)));

endmodule

// File: rtl/fg_enable_bank.sv
module fg_enable_bank
    import flash_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [PSEC_N-1:0] prog_en,
    output logic [DSEC_N-1:0] data_en
);

    genvar g;
    generate
        for (g = 0; g < PROG_REGS; g++) begin : g_prog
            logic [REG_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= '0;
                end else if (we && (sel == SEL_W'(g))) begin
                    r <= wdata;
                end
            end
            assign prog_en[g*REG_W +: REG_W] = r;
        end

        for (g = 0; g < DATA_REGS; g++) begin : g_data
            logic [REG_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= '0;
                end else if (we && (sel == SEL_W'(PROG_REGS + g))) begin
                    r <= wdata;
                end
            end
            assign data_en[g*REG_W +: REG_W] = r;
        end
    endgenerate

    p_enables_cleared_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prog_en == '0 && data_en == '0));

    p_unused_sel_r11: assert property (@(posedge clk) disable iff (rst)
        (we && int'(sel) >= NUM_REGS) |=> ($stable(prog_en) && $stable(data_en)));

endmodule

// File: rtl/fg_region_map.sv
module fg_region_map
    import flash_guard_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] boot_end,
    output locate_t           loc
);

    logic [ADDR_W-1:0] data_off;
    logic              in_boot;
    logic              in_code;
    logic              in_data;

    always_comb begin
        data_off = addr - DATA_BASE;
        in_boot  = (addr <= boot_end);
        in_code  = !in_boot && (addr <= CODE_TOP);
        in_data  = (addr >= DATA_BASE) && (addr <= DATA_LAST);

        if (in_boot)      loc.rgn = RGN_BOOT;
        else if (in_code) loc.rgn = RGN_CODE;
        else if (in_data) loc.rgn = RGN_DATA;
        else              loc.rgn = RGN_NONE;

        loc.psec = addr[PSEC_SHIFT +: PSEC_IDX_W];
        loc.dsec = data_off[DSEC_SHIFT +: DSEC_IDX_W];
    end

endmodule

// File: rtl/fg_policy.sv
module fg_policy
    import flash_guard_pkg::*;
(
    input  access_t           req,
    input  locate_t           loc,
    input  logic [PSEC_N-1:0] prog_en,
    input  logic [DSEC_N-1:0] data_en,
    input  global_lock_t      locks,
    output verdict_t          verdict
);

    logic ok_read;
    logic ok_write;
    logic section_open;
    logic ok;

    always_comb begin
        unique case (loc.rgn)
            RGN_CODE: section_open = prog_en[loc.psec];
            RGN_DATA: section_open = data_en[loc.dsec];
            default:  section_open = 1'b0;
        endcase

        ok_read  = (loc.rgn != RGN_NONE) && !(req.who == REQ_EXT && locks.rd_lock);
        ok_write = section_open && !locks.wr_lock;
        ok       = req.write ? ok_write : ok_read;

        verdict.grant = req.valid && ok;
        verdict.deny  = req.valid && !ok;
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cfg_boot_end,
    input  logic [PWORD_W-1:0] cfg_prot_word,
    input  logic               reg_we,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               acc_valid,
    input  logic               acc_ext,
    input  logic               acc_write,
    input  logic [ADDR_W-1:0]  acc_addr,
    output logic               acc_grant,
    output logic               acc_err
);

    logic [ADDR_W-1:0] boot_end;
    global_lock_t      locks;
    logic [PSEC_N-1:0] prog_en;
    logic [DSEC_N-1:0] data_en;
    access_t           req;
    locate_t           loc;
    verdict_t          verdict_d;
    verdict_t          verdict_q;

    always_comb begin
        req.valid = acc_valid;
        req.who   = acc_ext ? REQ_EXT : REQ_CPU;
        req.write = acc_write;
        req.addr  = acc_addr;
    end

    fg_cfg_latch u_cfg (
        .clk         (clk),
        .rst         (rst),
        .boot_end_in (cfg_boot_end),
        .prot_in     (cfg_prot_word),
        .boot_end    (boot_end),
        .locks       (locks)
    );

    fg_enable_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .prog_en (prog_en),
        .data_en (data_en)
    );

    fg_region_map u_map (
        .addr     (req.addr),
        .boot_end (boot_end),
        .loc      (loc)
    );

    fg_policy u_policy (
        .req     (req),
        .loc     (loc),
        .prog_en (prog_en),
        .data_en (data_en),
        .locks   (locks),
        .verdict (verdict_d)
    );

    always_ff @(posedge clk) begin
        if (rst) verdict_q <= '0;
        else     verdict_q <= verdict_d;
    end

    assign acc_grant = verdict_q.grant;
    assign acc_err   = verdict_q.deny;

    p_one_verdict_r9: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (acc_grant != acc_err));

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!acc_grant && !acc_err));

    p_boot_locked_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && loc.rgn == RGN_BOOT) |=> acc_err);

    p_global_wr_lock_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && locks.wr_lock) |=> !acc_grant);

    p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && loc.rgn == RGN_NONE) |=> acc_err);

    p_cpu_read_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !acc_ext && loc.rgn != RGN_NONE) |=> acc_grant);

endmodule

// File: tb/test_flash_guard.sv
module test_flash_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] cfg_boot_end = '0;
    logic [5:0]  cfg_prot_word = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_ext = 1'b0;
    logic        acc_write = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_grant;
    logic        acc_err;

    int checks = 0;
    int failures = 0;

    // Reference model state
    int       m_boot;
    bit       m_wp;
    bit       m_rp;
    bit [31:0] m_pen;
    bit [15:0] m_den;

    always #2 clk = ~clk;

    flash_guard i_flash_guard (
        .clk(clk), .rst(rst),
        .cfg_boot_end(cfg_boot_end), .cfg_prot_word(cfg_prot_word),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .acc_valid(acc_valid), .acc_ext(acc_ext), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_grant(acc_grant), .acc_err(acc_err)
    );

    function automatic bit votes_clear(input bit [2:0] v);
        int z = 0;
        for (int i = 0; i < 3; i++) if (v[i] == 1'b0) z = z + 1;
        return z >= 2;
    endfunction

    function automatic bit model_allow(input bit ext, input bit wr, input int a);
        int area;
        if (a <= m_boot)                       area = 1;
        else if (a <= 'h3FFFF)                 area = 2;
        else if (a >= 'hD0000 && a <= 'hD1FFF) area = 3;
        else                                   return 1'b0;
        if (!wr) return !(ext && m_rp);
        if (area == 1 || m_wp) return 1'b0;
        if (area == 2) return m_pen[a / 8192];
        return m_den[(a - 'hD0000) / 512];
    endfunction

    task automatic check2(input string tag, input bit g, input bit e, input bit eg, input bit ee);
        checks++;
        if (g !== eg || e !== ee) begin
            failures++;
            $display("FAIL %s: grant=%0b err=%0b expected grant=%0b err=%0b", tag, g, e, eg, ee);
        end
    endtask

    task automatic do_reset(input int boot_in, input bit [5:0] pw);
        @(negedge clk);
        rst = 1'b1;
        acc_valid = 1'b0;
        reg_we = 1'b0;
        cfg_boot_end = boot_in[19:0];
        cfg_prot_word = pw;
        repeat (3) @(posedge clk);
        #1 check2("R1 reset outputs", acc_grant, acc_err, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        m_boot = (boot_in > 'h77FF) ? 'h77FF : boot_in;
        m_wp = votes_clear(pw[2:0]);
        m_rp = votes_clear(pw[5:3]);
        m_pen = '0;
        m_den = '0;
    endtask

    task automatic step(input string tag, input bit v, input bit ext, input bit wr, input int a,
                        input bit we = 1'b0, input int sel = 0, input int wd = 0);
        bit ok;
        @(negedge clk);
        acc_valid = v; acc_ext = ext; acc_write = wr; acc_addr = a[19:0];
        reg_we = we; reg_sel = sel[1:0]; reg_wdata = wd[15:0];
        ok = model_allow(ext, wr, a);
        @(posedge clk);
        #1;
        check2(tag, acc_grant, acc_err, v && ok, v && !ok);
        if (we) begin
            if (sel == 0) m_pen[15:0] = wd[15:0];
            else if (sel == 1) m_pen[31:16] = wd[15:0];
            else if (sel == 2) m_den = wd[15:0];
        end
        @(negedge clk);
        reg_we = 1'b0;
        acc_valid = 1'b0;
    endtask

    task automatic setreg(input int sel, input int wd);
        step("R11 reg write idle", 1'b0, 1'b0, 1'b0, 0, 1'b1, sel, wd);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Phase A: boot end 0x1FFF, both global votes off (all ones)
        do_reset('h1FFF, 6'b111_111);
        step("R1 code write after reset", 1, 0, 1, 'h4000);
        step("R1 data write after reset", 1, 0, 1, 'hD0000);
        step("R7 cpu read boot", 1, 0, 0, 'h0000);
        step("R7 ext read code open", 1, 1, 0, 'h20000);
        step("R9 idle", 0, 0, 1, 'h4000);
        // Same-cycle write: request judged with old enables
        step("R11 same-cycle write old value", 1, 0, 1, 'h2000, 1, 0, 'hFFFF);
        step("R11 new value applied", 1, 0, 1, 'h2000);
        step("R2 boot write with enables", 1, 0, 1, 'h0000);
        step("R2 boot last byte", 1, 0, 1, 'h1FFF);
        step("R2 ext boot write", 1, 1, 1, 'h1000);
        step("R4 low reg section 15", 1, 0, 1, 'h1FFFF);
        step("R4 high reg not set sec16", 1, 0, 1, 'h20000);
        setreg(1, 'h8001);
        step("R4 sec16 via high reg", 1, 0, 1, 'h20000);
        step("R4 sec31 top address", 1, 0, 1, 'h3FFFF);
        step("R4 sec17 still closed", 1, 0, 1, 'h22000);
        setreg(0, 'h0004);
        step("R4 sec2 only", 1, 0, 1, 'h4000);
        step("R4 sec1 cleared", 1, 0, 1, 'h3FFF);
        step("R5 data sec1 closed", 1, 0, 1, 'hD0200);
        setreg(2, 'h0002);
        step("R5 data sec1 open", 1, 0, 1, 'hD03FF);
        step("R5 data sec0 closed", 1, 0, 1, 'hD01FF);
        step("R5 data sec15 closed", 1, 0, 1, 'hD1FFF);
        setreg(3, 'hFFFF);
        step("R11 sel3 ignored data", 1, 0, 1, 'hD1FFF);
        step("R11 sel3 ignored code", 1, 0, 1, 'h22000);
        step("R8 above code read", 1, 0, 0, 'h40000);
        step("R8 below data write", 1, 0, 1, 'hCFFFF);
        step("R8 above data read", 1, 1, 0, 'hD2000);
        step("R7 cpu read data", 1, 0, 0, 'hD1000);

        // Phase B: boot end too large, write vote one zero (off), read vote two zeros (on)
        do_reset('hFFFFF, 6'b001_110);
        cfg_boot_end = '0;
        cfg_prot_word = 6'b000_000;
        setreg(0, 'hFFFF);
        step("R3 clamped boot last", 1, 0, 1, 'h77FF);
        step("R3 first code byte", 1, 0, 1, 'h7800);
        step("R10 pins changed boot held", 1, 0, 1, 'h0100);
        step("R7 ext read blocked", 1, 1, 0, 'h0100);
        step("R7 cpu read allowed", 1, 0, 0, 'h0100);
        step("R7 ext write follows write rules", 1, 1, 1, 'h7800);
        step("R10 wr vote held after pins", 1, 0, 1, 'hA000);

        // Phase C: write vote two zeros (on), read vote all ones (off)
        do_reset('h0FFF, 6'b111_010);
        setreg(0, 'hFFFF);
        setreg(1, 'hFFFF);
        setreg(2, 'hFFFF);
        step("R6 code write global lock", 1, 0, 1, 'h4000);
        step("R6 data write global lock", 1, 0, 1, 'hD0000);
        step("R6 read unaffected", 1, 1, 0, 'h4000);
        step("R9 idle after lock", 0, 1, 0, 'h4000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule